// File: doc/BRIEF.md
# Dual Watchdog with Configuration Byte

This block holds one 8-bit control byte and runs two watchdogs that both count rising edges of an external monitored clock. The processor watchdog, once enabled, issues a one-cycle reset pulse when the monitored clock has produced a set number of edges. Software keeps it alive by writing its enable bit to 0 and then back to 1, which restarts the count. The clock watchdog acts as a presence detector. Once it is enabled, its bit reads back as 1. After the monitored clock has produced its own, shorter, number of edges, the bit reads back as 0. Clearing and then setting the bit arms it again.

The byte also stores three plain mode bits that drive output pins: a direct parallel access enable, a retime enable for a side message channel, and a loopback/output-disable enable for that channel. The monitored clock passes through a multi-stage synchronizer into the system clock domain. Each rising edge there becomes a one-cycle tick. The system clock must run at more than twice the monitored clock rate. Both timeouts are parameters given in monitored-clock edges, so a simulation can use short values and silicon can use the real intervals.

Top module: `dual_watchdog`

## Requirements
- R1: After reset, `rd_data` reads 0x00, `wd_rst` is low and all three mode outputs are low.
- R2: Byte layout: bit 0 drives `par_access_en`, bit 1 enables the processor watchdog, bit 2 enables the clock watchdog, bit 4 drives `link_retime_en` and bit 5 drives `link_loop_en`. Bits 3, 6 and 7 always read 0, and writes to them are ignored.
- R3: With bit 1 set, `wd_rst` stays low through the first PWD_TICKS-1 monitored rising edges. It pulses after edge number PWD_TICKS.
- R4: The `wd_rst` pulse lasts exactly one system clock cycle, and the same clock edge clears bit 1. No further pulse follows until bit 1 is set again.
- R5: Writing bit 1 as 0 and then as 1 restarts the count, so a full PWD_TICKS edges are needed after the second write.
- R6: Writing 1 to bit 1 while it is already 1 does not restart the count.
- R7: While bit 1 is 0, monitored edges produce no reset and are not counted. Counting starts from zero once the bit is set.
- R8: After bit 2 is set, it reads 1 through PWD-independent CWD_TICKS-1 monitored edges and reads 0 after edge number CWD_TICKS.
- R9: Once expired, bit 2 keeps reading 0 when 1 is written over it. Writing 0 and then 1 makes it read 1 again for a full CWD_TICKS edges.
- R10: While the monitored clock is still, an armed bit 2 keeps reading 1 indefinitely. A monitored high phase of any length counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Value written to the control byte |
| rd_data | output | 8 | Readback of the control byte, with live clock-watchdog status on bit 2 |
| mon_clk | input | 1 | Monitored clock, asynchronous to `clk` |
| wd_rst | output | 1 | One-cycle reset pulse from the processor watchdog |
| par_access_en | output | 1 | Direct parallel access enable (bit 0) |
| link_retime_en | output | 1 | Side-channel transmit retime enable (bit 4) |
| link_loop_en | output | 1 | Side-channel output disable with loopback (bit 5) |

## Verification
The bench counts monitored edges up to one short of each timeout and checks for silence there. It then gives one more edge and expects the event. A counter that is off by one would fire early or late. It checks that rewriting 1 over a set enable leaves the count alone, while a 0-then-1 pair restarts it. A design that restarts on any write would swallow the reset, and one that ignores the pair would fire early. It also checks that edges arriving while a watchdog is disabled are not carried into the next enable, and that a monitored high phase lasting many system cycles is counted once. A level-sensitive counter would time out far too soon.

// File: rtl/wdu_pkg.sv
package wdu_pkg;

  localparam int BYTE_W    = 8;
  localparam int POS_PAR   = 0;
  localparam int POS_PWD   = 1;
  localparam int POS_CWD   = 2;
  localparam int POS_RET   = 4;
  localparam int POS_LOOP  = 5;

  typedef struct packed {
    logic par_en;
    logic pwd_en;
    logic cwd_en;
    logic ret_en;
    logic loop_en;
  } cfg_t;

  // Decode a written byte into the stored fields; reserved positions drop out.
  function automatic cfg_t unpack_byte(input logic [BYTE_W-1:0] b);
    cfg_t c;
    c.par_en  = b[POS_PAR];
    c.pwd_en  = b[POS_PWD];
    c.cwd_en  = b[POS_CWD];
    c.ret_en  = b[POS_RET];
    c.loop_en = b[POS_LOOP];
    return c;
  endfunction

  // Assemble the readback byte; the clock watchdog position shows live status.
  function automatic logic [BYTE_W-1:0] pack_byte(input cfg_t c, input logic cwd_live);
    logic [BYTE_W-1:0] b;
    b           = '0;
    b[POS_PAR]  = c.par_en;
    b[POS_PWD]  = c.pwd_en;
    b[POS_CWD]  = cwd_live;
    b[POS_RET]  = c.ret_en;
    b[POS_LOOP] = c.loop_en;
    return b;
  endfunction

  // True when the counter sits on the final edge before the limit.
  function automatic logic at_last(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) == limit;
  endfunction

endpackage

// File: rtl/wdu_edge_sync.sv
module wdu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_tick
);

  localparam int CHAIN = (STAGES < 2) ? 2 : STAGES;

  logic [CHAIN-1:0] chain_q;
  logic             last_q;
  logic             tick_q;

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      last_q <= chain_q[CHAIN-1];
      tick_q <= chain_q[CHAIN-1] & ~last_q;
    end
  end

  assign rise_tick = tick_q;

endmodule

// File: rtl/wdu_timer.sv
module wdu_timer #(
  parameter int unsigned LIMIT      = 4,
  parameter bit          AUTO_CLEAR = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic expire_evt,
  output logic status_q
);
  import wdu_pkg::*;

  localparam int unsigned LIM = (LIMIT < 1) ? 1 : LIMIT;
  localparam int          CW  = $clog2(LIM + 1);

  logic [CW-1:0] cnt_q;
  logic          held;
  logic          last;

  assign last       = at_last(int'(cnt_q), LIM);
  assign expire_evt = arm & tick & last & ~held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!arm)           cnt_q <= '0;
    else if (expire_evt)     cnt_q <= AUTO_CLEAR ? '0 : cnt_q;
    else if (tick && !held)  cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (AUTO_CLEAR) begin : g_pulse
      // Reset-style variant: status is a one-cycle pulse per expiry.
      assign held = 1'b0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= expire_evt;
      end
    end else begin : g_sticky
      // Presence-style variant: status stays set until disarmed.
      assign held = status_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          status_q <= 1'b0;
        else if (!arm)       status_q <= 1'b0;
        else if (expire_evt) status_q <= 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/wdu_cfg_reg.sv
module wdu_cfg_reg (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [wdu_pkg::BYTE_W-1:0] wr_data,
  input  logic                   pwd_expire,
  output wdu_pkg::cfg_t          cfg_q
);
  import wdu_pkg::*;

  cfg_t wr_cfg;
  cfg_t cfg_d;

  assign wr_cfg = unpack_byte(wr_data);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en)           cfg_d = wr_cfg;
    else if (pwd_expire) cfg_d.pwd_en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

endmodule

// File: rtl/dual_watchdog.sv
module dual_watchdog #(
  parameter int unsigned PWD_TICKS   = 8192000,
  parameter int unsigned CWD_TICKS   = 4000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       mon_clk,
  output logic       wd_rst,
  output logic       par_access_en,
  output logic       link_retime_en,
  output logic       link_loop_en
);
  import wdu_pkg::*;

  cfg_t cfg_q;
  logic mon_tick;
  logic pwd_arm;
  logic cwd_arm;
  logic pwd_expire;
  logic cwd_expire;
  logic cwd_done;
  logic cwd_live;

  wdu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(mon_clk), .rise_tick(mon_tick)
  );

  wdu_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .pwd_expire(pwd_expire), .cfg_q(cfg_q)
  );

  assign pwd_arm = cfg_q.pwd_en;
  assign cwd_arm = cfg_q.cwd_en;

  wdu_timer #(.LIMIT(PWD_TICKS), .AUTO_CLEAR(1'b1)) u_pwd (
    .clk(clk), .rst_n(rst_n), .arm(pwd_arm), .tick(mon_tick),
    .expire_evt(pwd_expire), .status_q(wd_rst)
  );

  wdu_timer #(.LIMIT(CWD_TICKS), .AUTO_CLEAR(1'b0)) u_cwd (
    .clk(clk), .rst_n(rst_n), .arm(cwd_arm), .tick(mon_tick),
    .expire_evt(cwd_expire), .status_q(cwd_done)
  );

  assign cwd_live       = cwd_arm & ~cwd_done;
  assign rd_data        = pack_byte(cfg_q, cwd_live);
  assign par_access_en  = cfg_q.par_en;
  assign link_retime_en = cfg_q.ret_en;
  assign link_loop_en   = cfg_q.loop_en;

endmodule

// File: rtl/dual_watchdog_chk.sv
module dual_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       wd_rst,
  input logic       pwd_arm,
  input logic       mon_tick,
  input logic       cwd_expire
);

  AST_RST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst); // R4

  AST_RST_DROPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_rst && !$past(wr_en)) |-> !rd_data[1]); // R4

  AST_RST_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |-> ($past(pwd_arm) && $past(mon_tick))); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3] == 1'b0) && (rd_data[7:6] == 2'b00)); // R2

  AST_CWD_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_data[2]) && !$past(wr_en)) |-> $past(cwd_expire)); // R8

  AST_CWD_RISE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> $past(wr_en)); // R9

endmodule

bind dual_watchdog dual_watchdog_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .wd_rst(wd_rst), .pwd_arm(pwd_arm), .mon_tick(mon_tick),
  .cwd_expire(cwd_expire)
);

// File: tb/test_dual_watchdog.sv
`timescale 1ns/1ps
module test_dual_watchdog;

  localparam int PWD = 12;
  localparam int CWD = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       mon_clk = 1'b0;
  logic       wd_rst;
  logic       par_access_en, link_retime_en, link_loop_en;

  int checks = 0;
  int errors = 0;
  int rst_seen = 0;
  bit rst_wide = 1'b0;
  bit rst_prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_watchdog #(.PWD_TICKS(PWD), .CWD_TICKS(CWD), .SYNC_STAGES(2)) i_dual_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .mon_clk(mon_clk), .wd_rst(wd_rst), .par_access_en(par_access_en),
    .link_retime_en(link_retime_en), .link_loop_en(link_loop_en)
  );

  always @(negedge clk) begin
    if (rst_n && wd_rst) begin
      rst_seen++;
      if (rst_prev) rst_wide = 1'b1;
    end
    rst_prev = rst_n && wd_rst;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic edges(input int n, input int high = 3);
    for (int i = 0; i < n; i++) begin
      mon_clk = 1'b1; idle(high);
      mon_clk = 1'b0; idle(3);
    end
    idle(4);
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 wd_rst", wd_rst, 0);
    chk("R1 mode pins", {par_access_en, link_retime_en, link_loop_en}, 0);
  endtask

  task automatic t_layout;
    wr(8'hFF);
    chk("R2 all-ones readback", rd_data, 8'h37);
    chk("R2 mode pins", {par_access_en, link_retime_en, link_loop_en}, 3'b111);
    wr(8'hC9);
    chk("R2 reserved ignored", rd_data, 8'h01);
    chk("R2 pins after C9", {par_access_en, link_retime_en, link_loop_en}, 3'b100);
    wr(8'h00);
    chk("R2 cleared", rd_data, 8'h00);
  endtask

  task automatic t_disabled_then_run;
    rst_seen = 0;
    edges(PWD + 3);
    chk("R7 no reset while disabled", rst_seen, 0);
    wr(8'h02);
    edges(PWD - 1);
    chk("R3 silent before limit", rst_seen, 0);
    chk("R7 fresh count", rd_data[1], 1);
    edges(1);
    chk("R3 pulse at limit", rst_seen, 1);
    chk("R4 single cycle", rst_wide, 0);
    chk("R4 enable cleared", rd_data[1], 0);
    edges(PWD + 1);
    chk("R4 no repeat", rst_seen, 1);
  endtask

  task automatic t_restart;
    rst_seen = 0;
    wr(8'h02);
    edges(PWD - 4);
    wr(8'h00);
    wr(8'h02);
    edges(PWD - 1);
    chk("R5 restart delays reset", rst_seen, 0);
    edges(1);
    chk("R5 reset after full interval", rst_seen, 1);
  endtask

  task automatic t_rewrite_no_restart;
    rst_seen = 0;
    wr(8'h02);
    edges(PWD - 4);
    wr(8'h02);
    edges(4);
    chk("R6 rewrite keeps count", rst_seen, 1);
  endtask

  task automatic t_clock_wd;
    wr(8'h04);
    chk("R8 armed reads 1", rd_data[2], 1);
    idle(200);
    chk("R10 still clock holds 1", rd_data[2], 1);
    edges(1, 40);
    edges(CWD - 2);
    chk("R10 long high counted once", rd_data[2], 1);
    edges(1);
    chk("R8 expires at limit", rd_data[2], 0);
    wr(8'h04);
    chk("R9 overwrite stays 0", rd_data[2], 0);
    wr(8'h00);
    chk("R9 cleared", rd_data[2], 0);
    wr(8'h04);
    chk("R9 rearmed", rd_data[2], 1);
    edges(CWD - 1);
    chk("R9 full interval", rd_data[2], 1);
    edges(1);
    chk("R9 expires again", rd_data[2], 0);
    wr(8'h00);
  endtask

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_layout;
    t_disabled_then_run;
    t_restart;
    t_rewrite_no_restart;
    t_clock_wd;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule